// File: doc/BRIEF.md
# Load-and-Shift Serial Result Output

This block takes a parallel conversion result and sends it out one bit at a time on a single pin. It saves pins on a low-pin-count sensing chip. A load strobe copies the whole word into a chain of flip-flops. Each stage has a 2:1 selector in front of it, so while the strobe is high every stage takes its own parallel input bit. While the strobe is low, every shift step moves the word one stage toward the output. The most significant bit leaves first.

The output pin is driven through an inverting buffer, so a receiver must complement the bit string it collects. For example, a received string 1011110010 decodes to 0100001101, which is 269. The least significant stage takes its own value back in when the word moves. Once every bit has been presented, the last bit therefore stays on the pin until the next load.

A step counter raises a word-complete flag once the word has moved as many times as it has stages. A load that arrives part-way through a word drops the old word and starts again with the new data.

The shift clock is slow (nominally 4 kHz). Inside the chip it is modelled as a one-cycle step enable on the block clock. An outside agent drives the load strobe and the step enable directly; there is no handshake.

Top module: `result_serializer`

## Requirements
- R1: While reset is asserted, and after it is released with no load yet, `serOut` is 1 (the stored word is all zeros, inverted) and `wordDone` is 0.
- R2: A cycle with `loadIn` high stores `parIn`. From the next cycle on, `serOut` shows the inverse of `parIn[WIDTH-1]`.
- R3: If `loadIn` and `shiftStep` are both high in the same cycle, the load wins and no shift takes place.
- R4: Each cycle with `shiftStep` high and `loadIn` low moves the word one stage. After k such steps following a load, `serOut` shows the inverse of bit WIDTH-1-k of the loaded word. Bits leave most significant first.
- R5: After WIDTH-1 steps, `serOut` shows the inverted least significant bit. Further steps keep showing that same bit until the next load.
- R6: In a cycle with neither `loadIn` nor `shiftStep` high, `serOut` does not change.
- R7: A load in the middle of a word discards the rest of that word. Output and step counting restart from the new word's most significant bit.
- R8: `wordDone` rises in the cycle after the WIDTH-th step since the last load or reset. It stays high until the next load, and it falls in the cycle after that load.
- R9: The default WIDTH is 10. With a stored word of 269, the bits seen on `serOut`, first to last, are 1011110010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loadIn | input | 1 | Load strobe: copy the parallel word into the chain |
| shiftStep | input | 1 | One-cycle enable standing for one serial clock edge |
| parIn | input | WIDTH | Parallel conversion result |
| serOut | output | 1 | Inverted serial bit, most significant first |
| wordDone | output | 1 | High once all WIDTH steps since the last load have happened |

## Verification
Every result is due exactly one clock after the stimulus that causes it. A load, a step, or a load that wins over a step all change `serOut` and `wordDone` after a single register stage, and an idle cycle changes nothing. The bench drives inputs on the falling edge and moves a behavioural model (a bit position and a step count) on the rising edge. It compares both outputs on the next falling edge, so every comparison lands one cycle after its stimulus. Directed phases cover the decode example, collisions, mid-word reloads and holding the last bit. A random phase then mixes loads and steps.

// File: rtl/serializer_pkg.sv
package serializer_pkg;
  // Strobes from control to datapath; at most one is set in a cycle.
  typedef struct packed {
    logic capture;  // take the parallel word
    logic advance;  // move the word one stage toward the pin
  } serStrobe_t;
endpackage

// File: rtl/serializer_ctrl.sv
module serializer_ctrl
  import serializer_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loadIn,
  input  logic       shiftStep,
  output serStrobe_t strobe,
  output logic       wordDone
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);
  localparam logic [CW-1:0] FULL = CW'(WIDTH);

  logic [CW-1:0] stepCnt;
  logic          doneQ;

  // A load takes priority over a step in the same cycle.
  always_comb begin
    strobe.capture = loadIn;
    strobe.advance = shiftStep & ~loadIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else if (strobe.capture) begin
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else if (strobe.advance && stepCnt != FULL) begin
      stepCnt <= stepCnt + 1'b1;
      if (stepCnt == LAST_STEP) doneQ <= 1'b1;
    end
  end

  assign wordDone = doneQ;

  // R8: the flag and the step count agree
  assert_done_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ == (stepCnt == FULL));
  // R8: a load clears the flag in the next cycle
  assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loadIn |=> !doneQ);
  // R3: a step never reaches the datapath in a load cycle
  assert_load_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.capture && strobe.advance));
  // R7: a load restarts the count
  assert_count_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loadIn |=> stepCnt == '0);
endmodule

// File: rtl/serializer_datapath.sv
module serializer_datapath
  import serializer_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  serStrobe_t       strobe,
  input  logic [WIDTH-1:0] parIn,
  output logic             msbBit
);
  logic [WIDTH-1:0] stageQ;
  logic [WIDTH-1:0] stageD;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic chainIn;
      if (i == 0) begin : g_tail
        // The tail feeds back on itself, so the final bit repeats.
        assign chainIn = stageQ[0];
      end else begin : g_link
        assign chainIn = stageQ[i-1];
      end
      always_comb begin
        if (strobe.capture)      stageD[i] = parIn[i];
        else if (strobe.advance) stageD[i] = chainIn;
        else                     stageD[i] = stageQ[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stageQ <= '0;
    else        stageQ <= stageD;
  end

  assign msbBit = stageQ[WIDTH-1];

  // R2: a capture holds the parallel word one cycle later
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> stageQ == $past(parIn));
  // R4: a step moves the next lower bit to the head
  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> stageQ[WIDTH-1] == $past(stageQ[WIDTH-2]));
  // R5: the tail keeps its value on a step
  assert_tail_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> stageQ[0] == $past(stageQ[0]));
  // R6: an idle cycle changes no stage
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture && !strobe.advance |=> $stable(stageQ));
endmodule

// File: rtl/result_serializer.sv
module result_serializer
  import serializer_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loadIn,
  input  logic             shiftStep,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut,
  output logic             wordDone
);
  serStrobe_t strobe;
  logic       msbBit;

  serializer_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .loadIn(loadIn), .shiftStep(shiftStep),
    .strobe(strobe), .wordDone(wordDone)
  );

  serializer_datapath #(.WIDTH(WIDTH)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .parIn(parIn), .msbBit(msbBit)
  );

  // Inverting pin buffer.
  assign serOut = ~msbBit;

  // R6: the pin only moves after a load or a step
  assert_pin_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !loadIn && !shiftStep |=> $stable(serOut));
endmodule

// File: tb/result_serializer_bench.sv
`timescale 1ns/1ps
module result_serializer_bench;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadIn = 1'b0;
  logic shiftStep = 1'b0;
  logic [W-1:0] parIn = '0;
  logic serOut, wordDone;

  int checks = 0;
  int errors = 0;

  // Behavioural model: word, index of the bit on the pin, steps since load.
  logic [W-1:0] mWord = '0;
  int mPos = W - 1;
  int mSteps = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  result_serializer #(.WIDTH(W)) u_result_serializer (
    .clk(clk), .rst_n(rst_n), .loadIn(loadIn), .shiftStep(shiftStep),
    .parIn(parIn), .serOut(serOut), .wordDone(wordDone)
  );

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(tag, serOut, ~mWord[mPos], "serOut");
    check((tag == "R7") ? "R7" : "R8", wordDone, (mSteps >= W), "wordDone");
  endtask

  // Drive on the falling edge, update the model on the rising edge,
  // compare on the next falling edge.
  task automatic cyc(logic ld, logic st, logic [W-1:0] d, string req);
    loadIn = ld; shiftStep = st; parIn = d; tag = req;
    @(posedge clk);
    if (ld) begin
      mWord = d; mPos = W - 1; mSteps = 0;
    end else if (st) begin
      if (mPos > 0) mPos--;
      if (mSteps < W) mSteps++;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] seen;
    @(negedge clk);
    @(negedge clk);
    check("R1", serOut, 1'b1, "serOut in reset");
    check("R1", wordDone, 1'b0, "wordDone in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", serOut, 1'b1, "serOut after reset");
    check("R1", wordDone, 1'b0, "wordDone after reset");

    // R9: decode example, 269 gives 1011110010 on the pin
    cyc(1, 0, W'(269), "R2");
    seen = '0;
    seen[W-1] = serOut;
    for (int k = 1; k < W; k++) begin
      cyc(0, 1, '0, "R4");
      seen[W-1-k] = serOut;
    end
    checks++;
    if (seen !== 10'b1011110010) begin
      errors++;
      $display("FAIL R9 pin string actual=%b expected=%b", seen, 10'b1011110010);
    end
    // R5: keep stepping, last bit holds; R8 flag on the tenth step
    for (int k = 0; k < 4; k++) cyc(0, 1, '0, "R5");
    // R6: idle cycles
    for (int k = 0; k < 3; k++) cyc(0, 0, '1, "R6");

    // R3: load and step together, load wins
    cyc(1, 1, 10'b1100110011, "R3");
    cyc(0, 1, '0, "R3");
    cyc(0, 0, '0, "R6");
    // R7: reload mid-word
    cyc(0, 1, '0, "R4");
    cyc(0, 1, '0, "R4");
    cyc(1, 0, 10'b0011111110, "R7");
    for (int k = 0; k < W + 2; k++) cyc(0, 1, '0, "R7");
    cyc(1, 0, 10'b1000000001, "R8");
    for (int k = 0; k < W + 1; k++) cyc(0, (k % 2) == 0, '0, "R8");

    // Mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 15));
      cyc(r == 0, r > 6, W'($urandom), (r == 0) ? "R7" : ((r > 6) ? "R4" : "R6"));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule